// File: doc/BRIEF.md
# Key-Unlocked Configuration Index Port

This block is the configuration-space front end of an I/O-mapped peripheral controller. It decodes a two-byte window on an 8-bit I/O bus. The lower address is an index port and the next address is a data port. The window stays closed after reset. Writing the open key to the index port unlocks it, and writing the close key locks it again. While the window is open, a byte written to the index port selects a register, and the data port then reads or writes that register.

Behind the window are a read-only device identifier, a logical-device number and three registers banked per logical device: an activate flag and the two bytes of a 16-bit runtime base address. The base address and activate flag of one designated logical device, the runtime block, are driven out continuously for downstream address decoding.

The bus has no back-pressure. A strobe is accepted in the cycle it is high. Writes take effect at that clock edge, and read data is valid combinationally in the same cycle as the read strobe.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the window is locked, every banked register and the logical-device number are zero, `rt_base` is 0x0000 and `rt_active` is 0.
- R2: While locked, an index-port write of 0x55 opens the window. Any other index-port byte leaves it locked and leaves the index unchanged.
- R3: While open, an index-port write of 0xAA locks the window. After that, data-port and index-port reads return 0xFF.
- R4: While locked, data-port writes change no register, and data-port reads return 0xFF.
- R5: While open, any other index-port byte is latched as the index, and reading the index port returns it. The data port then accesses the register that index selects.
- R6: Index 0x20 reads the device identifier: 0x7C, 0x7D or 0x7F for `DEV_VARIANT` 0, 1 or 2. Writes to it have no effect.
- R7: Index 0x07 is the read/write logical-device number (8 bits).
- R8: Index 0x30 is the activate flag of the selected logical device. Only bit 0 is stored, and bits 7..1 read as 0.
- R9: Indexes 0x60 and 0x61 hold the high and low bytes of the selected device's base address. Each logical device keeps its own copy.
- R10: `rt_base` and `rt_active` follow the registers of logical device 0x0A. A write to them shows on the outputs one clock after the write strobe.
- R11: An index with no register reads 0x00. A read outside the window returns 0xFF, a write outside the window has no effect, and `io_rdata` is 0x00 when `io_rd` is low.
- R12: While the logical-device number is `NUM_LDEV` or above, banked writes are dropped and banked reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_rdata | output | 8 | Read data, combinational |
| rt_base | output | 16 | Runtime base address of logical device 0x0A |
| rt_active | output | 1 | Activate flag of logical device 0x0A |

## Verification
The window is driven with non-key index bytes while locked, with both keys, and with index/data pairs while open.
- Reading the index port back separates "ignored" from "latched".
- The same register offsets are written under two logical-device numbers, so a banked store can be told apart from one shared register.
- A number past the last device shows that writes to an absent bank are dropped.
- Writes to the runtime device are checked on the dedicated outputs, to separate its entry from the others.
- Writes outside the window, and writes to the read-only identifier, show that decode and write protection keep the state unchanged.

// File: rtl/kcp_pkg.sv
package kcp_pkg;
  localparam logic [7:0] KEY_OPEN    = 8'h55;
  localparam logic [7:0] KEY_CLOSE   = 8'hAA;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_DEVID   = 8'h20;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] BUS_FLOAT   = 8'hFF;

  typedef enum logic {ST_LOCKED = 1'b0, ST_OPEN = 1'b1} lock_st_t;

  function automatic logic [7:0] devid_of(input int variant);
    case (variant)
      0:       return 8'h7C;
      1:       return 8'h7D;
      default: return 8'h7F;
    endcase
  endfunction
endpackage

// File: rtl/kcp_decode.sv
module kcp_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h002E
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic              idx_wr,
  output logic              dat_wr,
  output logic              idx_rd,
  output logic              dat_rd,
  output logic              miss_rd
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = WIN_BASE + ADDR_W'(1);

  logic hit_idx, hit_dat;

  assign hit_idx = (io_addr == WIN_BASE);
  assign hit_dat = (io_addr == DAT_ADDR);
  assign idx_wr  = io_wr & hit_idx;
  assign dat_wr  = io_wr & hit_dat;
  // a simultaneous write wins over a read
  assign idx_rd  = io_rd & ~io_wr & hit_idx;
  assign dat_rd  = io_rd & ~io_wr & hit_dat;
  assign miss_rd = io_rd & ~io_wr & ~hit_idx & ~hit_dat;
endmodule

// File: rtl/kcp_keylock.sv
module kcp_keylock
  import kcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open_o,
  output logic [7:0] index_o
);
  lock_st_t   st_q, st_d;
  logic [7:0] index_q, index_d;

  always_comb begin
    st_d    = st_q;
    index_d = index_q;
    if (idx_wr) begin
      if (st_q == ST_LOCKED) begin
        if (wdata == KEY_OPEN) st_d = ST_OPEN;
      end else if (wdata == KEY_CLOSE) begin
        st_d = ST_LOCKED;
      end else begin
        index_d = wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_LOCKED;
      index_q <= 8'h00;
    end else begin
      st_q    <= st_d;
      index_q <= index_d;
    end
  end

  assign open_o  = (st_q == ST_OPEN);
  assign index_o = index_q;

  assert_unlock_key_R2: assert property (@(posedge clk) disable iff (rst)
    (!open_o && idx_wr && wdata == KEY_OPEN) |=> open_o);
  assert_stay_locked_R2: assert property (@(posedge clk) disable iff (rst)
    (!open_o && !(idx_wr && wdata == KEY_OPEN)) |=> !open_o);
  assert_index_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    (!open_o) |=> $stable(index_o));
  assert_lock_key_R3: assert property (@(posedge clk) disable iff (rst)
    (open_o && idx_wr && wdata == KEY_CLOSE) |=> !open_o);
endmodule

// File: rtl/kcp_ldev_bank.sv
module kcp_ldev_bank
  import kcp_pkg::*;
#(
  parameter int NUM_LDEV = 16,
  parameter int RT_LDEV  = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  index,
  input  logic [7:0]  wdata,
  input  logic [7:0]  ldn,
  output logic [7:0]  rd_byte,
  output logic [15:0] rt_base_o,
  output logic        rt_active_o
);
  localparam int LDN_W = $clog2(NUM_LDEV);

  logic [NUM_LDEV-1:0]       act_vec;
  logic [NUM_LDEV-1:0][15:0] base_vec;
  logic                      ldn_ok;
  logic [LDN_W-1:0]          sel;

  assign ldn_ok = (32'(ldn) < NUM_LDEV);
  assign sel    = ldn[LDN_W-1:0];

  for (genvar g = 0; g < NUM_LDEV; g++) begin : gen_dev
    logic        act_q;
    logic [15:0] base_q;
    logic        hit;

    assign hit = wr_en && (ldn == 8'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        act_q  <= 1'b0;
        base_q <= 16'h0000;
      end else if (hit) begin
        case (index)
          IDX_ACT:     act_q         <= wdata[0];
          IDX_BASE_HI: base_q[15:8]  <= wdata;
          IDX_BASE_LO: base_q[7:0]   <= wdata;
          default:     ;
        endcase
      end
    end

    assign act_vec[g]  = act_q;
    assign base_vec[g] = base_q;
  end

  always_comb begin
    rd_byte = 8'h00;
    if (ldn_ok) begin
      case (index)
        IDX_ACT:     rd_byte = {7'b0, act_vec[sel]};
        IDX_BASE_HI: rd_byte = base_vec[sel][15:8];
        IDX_BASE_LO: rd_byte = base_vec[sel][7:0];
        default:     rd_byte = 8'h00;
      endcase
    end
  end

  assign rt_base_o   = base_vec[RT_LDEV];
  assign rt_active_o = act_vec[RT_LDEV];

  assert_rt_lo_follow_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ldn == 8'(RT_LDEV) && index == IDX_BASE_LO) |=> (rt_base_o[7:0] == $past(wdata)));
  assert_rt_hi_follow_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ldn == 8'(RT_LDEV) && index == IDX_BASE_HI) |=> (rt_base_o[15:8] == $past(wdata)));
  assert_absent_dev_R12: assert property (@(posedge clk) disable iff (rst)
    (!ldn_ok) |=> $stable(base_vec) && $stable(act_vec));
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import kcp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h002E,
  parameter int DEV_VARIANT = 1,
  parameter int NUM_LDEV = 16,
  parameter int RT_LDEV = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [7:0]        io_rdata,
  output logic [15:0]       rt_base,
  output logic              rt_active
);
  localparam logic [7:0] DEV_ID = devid_of(DEV_VARIANT);

  logic       idx_wr, dat_wr, idx_rd, dat_rd, miss_rd;
  logic       open;
  logic [7:0] index;
  logic [7:0] ldn_q;
  logic [7:0] bank_rd;
  logic       cfg_wr;
  logic [7:0] reg_rd;

  kcp_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_decode (
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .idx_wr(idx_wr), .dat_wr(dat_wr), .idx_rd(idx_rd), .dat_rd(dat_rd),
    .miss_rd(miss_rd)
  );

  kcp_keylock u_keylock (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .wdata(io_wdata),
    .open_o(open), .index_o(index)
  );

  assign cfg_wr = dat_wr & open;

  always_ff @(posedge clk) begin
    if (rst)                            ldn_q <= 8'h00;
    else if (cfg_wr && index == IDX_LDN) ldn_q <= io_wdata;
  end

  kcp_ldev_bank #(.NUM_LDEV(NUM_LDEV), .RT_LDEV(RT_LDEV)) u_bank (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .index(index), .wdata(io_wdata),
    .ldn(ldn_q), .rd_byte(bank_rd), .rt_base_o(rt_base), .rt_active_o(rt_active)
  );

  always_comb begin
    case (index)
      IDX_DEVID:                     reg_rd = DEV_ID;
      IDX_LDN:                       reg_rd = ldn_q;
      IDX_ACT, IDX_BASE_HI, IDX_BASE_LO: reg_rd = bank_rd;
      default:                       reg_rd = 8'h00;
    endcase
  end

  always_comb begin
    io_rdata = 8'h00;
    if (miss_rd)     io_rdata = BUS_FLOAT;
    else if (idx_rd) io_rdata = open ? index : BUS_FLOAT;
    else if (dat_rd) io_rdata = open ? reg_rd : BUS_FLOAT;
  end

  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!open) |=> $stable(rt_base) && $stable(rt_active));
  assert_locked_read_R4: assert property (@(posedge clk) disable iff (rst)
    (!open && dat_rd) |-> io_rdata == BUS_FLOAT);
  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (rst)
    (!io_rd) |-> io_rdata == 8'h00);
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    $countones({idx_rd, dat_rd, miss_rd}) <= 1);
endmodule

// File: tb/keyed_cfg_port_bench.sv
module keyed_cfg_port_bench;
  localparam logic [15:0] IP = 16'h002E;
  localparam logic [15:0] DP = 16'h002F;
  localparam logic [15:0] XP = 16'h0030;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_rdata;
  logic [15:0] rt_base;
  logic        rt_active;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keyed_cfg_port u_keyed_cfg_port (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
    .rt_base(rt_base), .rt_active(rt_active)
  );

  // {op(1: read-check, 0: write), req(4), addr(16), data/expected(8)}
  localparam int NV = 40;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 4'd4,  DP, 8'hFF},  // R4 locked read
    {1'b0, 4'd2,  IP, 8'h13},  // R2 non-key while locked
    {1'b1, 4'd2,  DP, 8'hFF},
    {1'b0, 4'd4,  DP, 8'h99},  // R4 locked write
    {1'b0, 4'd2,  IP, 8'h55},  // R2 unlock
    {1'b1, 4'd2,  IP, 8'h00},  // R2 index untouched by 0x13
    {1'b0, 4'd6,  IP, 8'h20},
    {1'b1, 4'd6,  DP, 8'h7D},  // R6 identifier
    {1'b0, 4'd6,  DP, 8'h00},
    {1'b1, 4'd6,  DP, 8'h7D},  // R6 read-only
    {1'b0, 4'd7,  IP, 8'h07},
    {1'b1, 4'd7,  DP, 8'h00},  // R7 reset value
    {1'b0, 4'd7,  DP, 8'h0A},
    {1'b1, 4'd7,  DP, 8'h0A},  // R7
    {1'b0, 4'd9,  IP, 8'h60},
    {1'b0, 4'd9,  DP, 8'h12},
    {1'b0, 4'd9,  IP, 8'h61},
    {1'b0, 4'd9,  DP, 8'h34},
    {1'b0, 4'd8,  IP, 8'h30},
    {1'b0, 4'd8,  DP, 8'hFF},
    {1'b1, 4'd8,  DP, 8'h01},  // R8 only bit 0
    {1'b0, 4'd9,  IP, 8'h60},
    {1'b1, 4'd9,  DP, 8'h12},  // R9 high byte
    {1'b0, 4'd9,  IP, 8'h61},
    {1'b1, 4'd9,  DP, 8'h34},  // R9 low byte
    {1'b0, 4'd9,  IP, 8'h07},
    {1'b0, 4'd9,  DP, 8'h03},
    {1'b0, 4'd9,  IP, 8'h60},
    {1'b1, 4'd9,  DP, 8'h00},  // R9 device 3 separate
    {1'b0, 4'd9,  DP, 8'h56},
    {1'b1, 4'd9,  DP, 8'h56},
    {1'b0, 4'd9,  IP, 8'h07},
    {1'b0, 4'd9,  DP, 8'h0A},
    {1'b0, 4'd9,  IP, 8'h60},
    {1'b1, 4'd9,  DP, 8'h12},  // R9 device 10 kept
    {1'b0, 4'd11, IP, 8'h44},
    {1'b1, 4'd11, DP, 8'h00},  // R11 unknown index
    {1'b1, 4'd5,  IP, 8'h44},  // R5 index read back
    {1'b1, 4'd11, XP, 8'hFF},  // R11 outside window
    {1'b0, 4'd11, XP, 8'h00}   // R11 outside write (checked below)
  };

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    #1 io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #2 v = io_rdata;
    @(posedge clk);
    #1 io_rd = 1'b0;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #5;
    check(rt_base == 16'h0000, "R1", 32'(rt_base), 0);
    check(rt_active == 1'b0, "R1", 32'(rt_active), 0);
    check(io_rdata == 8'h00, "R11", 32'(io_rdata), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28]) begin
        io_read(VEC[i][23:8], v);
        check(v == VEC[i][7:0], $sformatf("R%0d vec%0d", VEC[i][27:24], i), 32'(v), 32'(VEC[i][7:0]));
      end else begin
        io_write(VEC[i][23:8], VEC[i][7:0]);
      end
    end

    // R10 runtime device outputs, and R11 outside write left them alone
    check(rt_base == 16'h1234, "R10", 32'(rt_base), 32'h1234);
    check(rt_active == 1'b1, "R10", 32'(rt_active), 1);
    io_write(IP, 8'h61);
    io_write(DP, 8'h77);
    check(rt_base == 16'h1277, "R10 next-cycle", 32'(rt_base), 32'h1277);
    io_write(IP, 8'h30);
    io_write(DP, 8'h00);
    check(rt_active == 1'b0, "R10 activate", 32'(rt_active), 0);
    io_write(DP, 8'h01);

    // R12 logical device beyond the bank
    io_write(IP, 8'h07);
    io_write(DP, 8'h20);
    io_read(DP, v);
    check(v == 8'h20, "R7 wide ldn", 32'(v), 32'h20);
    io_write(IP, 8'h60);
    io_write(DP, 8'hEE);
    io_read(DP, v);
    check(v == 8'h00, "R12 read", 32'(v), 0);
    check(rt_base == 16'h1277, "R12 no write", 32'(rt_base), 32'h1277);
    io_write(IP, 8'h07);
    io_write(DP, 8'h0A);

    // R3 lock and then confirm locked behaviour
    io_write(IP, 8'hAA);
    io_read(DP, v);
    check(v == 8'hFF, "R3 data", 32'(v), 32'hFF);
    io_read(IP, v);
    check(v == 8'hFF, "R3 index", 32'(v), 32'hFF);
    io_write(IP, 8'h60);
    io_write(DP, 8'h00);
    check(rt_base == 16'h1277, "R4 locked write", 32'(rt_base), 32'h1277);
    io_write(IP, 8'h55);
    io_read(IP, v);
    check(v == 8'h07, "R2 index kept while locked", 32'(v), 32'h07);
    io_read(DP, v);
    check(v == 8'h0A, "R5 data after reopen", 32'(v), 32'h0A);

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    check(rt_base == 16'h0000, "R1 rerst", 32'(rt_base), 0);
    check(rt_active == 1'b0, "R1 rerst", 32'(rt_active), 0);
    io_read(DP, v);
    check(v == 8'hFF, "R1 locked after reset", 32'(v), 32'hFF);

    finish_run();
  end
endmodule